// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block is a 16-bit down-counting timer peripheral with three registers on a plain 16-bit register bus. Software picks a prescaler divide, loads a modulus and starts the timer. The counter then steps down once per prescaled tick. When the counter is already zero on a tick, the timer expires and sets an interrupt flag. The level interrupt output is that flag gated by an interrupt-enable bit.

In reload mode the counter refills from the modulus at each expiry, so interrupts arrive periodically. With reload off, the block acts as a one-shot event source. The counter wraps to all-ones after expiry and keeps counting, and software arms each new event by writing the modulus. An optional immediate-load bit makes every modulus write replace the live count at once. Software clears the flag by writing 1 to its bit, so a read-modify-write of the control word also clears a pending flag.

Register map (byte offsets): control at 0, modulus at 2, count at 4. The control fields are: bit 0 autoload, bit 1 run, bit 2 event flag (write 1 to clear), bit 3 interrupt enable, bit 4 immediate load, bits 11:8 divide select. All other control bits read as zero.

Top module: `tmr_top`

## Requirements
- R1: After reset the control, modulus and count registers all read 0 and the interrupt output is low.
- R2: Control reads return the fields at their stated positions, with the other bits at zero. The modulus reads back the last value written. A write to the count offset (4) changes nothing.
- R3: With divide select n, one tick occurs every 2^(n+2) system cycles, counted from the cycle the counter was loaded. Select 5 gives 128 cycles, which is a divide by 64 of a half-rate timer clock. The prescaler is held cleared while run is 0.
- R4: A control write that sets run while run is 0 loads the count from the modulus. Each tick then lowers the count by 1. While run is 0 the count holds.
- R5: A tick with the count at 0 is an expiry, and it sets the flag. With autoload set, the count becomes the modulus value, so the period is modulus+1 ticks.
- R6: With autoload clear, an expiry sets the flag and the count wraps to 0xFFFF and keeps counting down.
- R7: A modulus write with immediate load set puts the written value into the count on the same clock and restarts the prescaler. Without immediate load, the count is left untouched.
- R8: Writing 1 to bit 2 of control clears the flag, and writing 0 there has no effect. An expiry in the same cycle as a clear wins, and the flag is set.
- R9: The interrupt output is high exactly when the flag and the interrupt-enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 3 | Register byte offset |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions check the following on every cycle:
- each tick step of the counter: decrement, autoload refill and wrap to all-ones;
- the immediate-load path;
- the flag set and clear priority;
- the prescaler idling while stopped;
- the interrupt gating.

Only the bench's scenarios can show the cycle-level tick spacing for each divide select, the register readback layout, and that writes to the count offset or plain modulus writes leave the count untouched. The count values after long runs with random modulus, divide and mode are compared against a closed-form tick model.

// File: rtl/tmr_pkg.sv
// Package: shared register offsets, control field positions and control type
// for the periodic interrupt timer. Assumes a 3-bit byte-offset address.
package tmr_pkg;
    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_MOD  = 3'd2;
    localparam logic [2:0] ADDR_CNT  = 3'd4;

    localparam int BIT_RELOAD = 0;
    localparam int BIT_RUN    = 1;
    localparam int BIT_FLAG   = 2;
    localparam int BIT_IE     = 3;
    localparam int BIT_OVW    = 4;
    localparam int SEL_LO     = 8;
    localparam int SEL_W      = 4;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             ovw;
        logic             ie;
        logic             run;
        logic             reload;
    } ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
// Module: register file. Holds control, modulus and event flag, decodes bus
// writes, makes the counter load strobe and muxes read data.
// Assumes single-cycle write strobes and combinational reads.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              expire_i,
    input  logic [DATA_W-1:0] cnt_i,
    output ctrl_t             ctrl_o,
    output logic [DATA_W-1:0] modulus_o,
    output logic              flag_o,
    output logic              load_o,
    output logic [DATA_W-1:0] load_val_o,
    output logic [DATA_W-1:0] rdata_o
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] mod_q;
    logic              flag_q;
    logic              wr_ctrl;
    logic              wr_mod;
    logic              start;

    // Decode writes and detect the run bit going from 0 to 1
    always_comb begin
        wr_ctrl = wr_en_i && (addr_i == ADDR_W'(ADDR_CTRL));
        wr_mod  = wr_en_i && (addr_i == ADDR_W'(ADDR_MOD));
        start   = wr_ctrl && wdata_i[BIT_RUN] && !ctrl_q.run;
    end

    // Control register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.sel    <= wdata_i[SEL_LO +: SEL_W];
            ctrl_q.ovw    <= wdata_i[BIT_OVW];
            ctrl_q.ie     <= wdata_i[BIT_IE];
            ctrl_q.run    <= wdata_i[BIT_RUN];
            ctrl_q.reload <= wdata_i[BIT_RELOAD];
        end
    end

    // Modulus register update
    always_ff @(posedge clk) begin
        if (!rst_n)      mod_q <= '0;
        else if (wr_mod) mod_q <= wdata_i;
    end

    // Event flag: an expiry sets it and takes priority over a write-1 clear
    always_ff @(posedge clk) begin
        if (!rst_n)                             flag_q <= 1'b0;
        else if (expire_i)                      flag_q <= 1'b1;
        else if (wr_ctrl && wdata_i[BIT_FLAG])  flag_q <= 1'b0;
    end

    // Counter load strobe and the value it loads
    always_comb begin
        load_o     = start || (wr_mod && ctrl_q.ovw);
        load_val_o = wr_mod ? wdata_i : mod_q;
    end

    // Read data mux
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(ADDR_CTRL): begin
                rdata_o[BIT_RELOAD]           = ctrl_q.reload;
                rdata_o[BIT_RUN]              = ctrl_q.run;
                rdata_o[BIT_FLAG]             = flag_q;
                rdata_o[BIT_IE]               = ctrl_q.ie;
                rdata_o[BIT_OVW]              = ctrl_q.ovw;
                rdata_o[SEL_LO +: SEL_W]      = ctrl_q.sel;
            end
            ADDR_W'(ADDR_MOD): rdata_o = mod_q;
            ADDR_W'(ADDR_CNT): rdata_o = cnt_i;
            default:           rdata_o = '0;
        endcase
    end

    assign ctrl_o    = ctrl_q;
    assign modulus_o = mod_q;
    assign flag_o    = flag_q;

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> flag_q);
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata_i[BIT_FLAG] && !expire_i) |=> !flag_q);
    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!expire_i && !(wr_ctrl && wdata_i[BIT_FLAG])) |=> $stable(flag_q));
endmodule

// File: rtl/tmr_prescale.sv
// Module: prescaler. Gives a one-cycle tick every 2^(sel+2) clock cycles
// while running. It is cleared on restart and held at zero while stopped.
module tmr_prescale #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int PRE_W = (1 << SEL_W) + 1;
    localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] lim;

    // Terminal count for the selected divide
    always_comb begin
        lim    = (ONE << (32'(sel_i) + 32'd2)) - ONE;
        tick_o = run_i && !restart_i && (pre_q == lim);
    end

    // Prescale counter
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || restart_i) pre_q <= '0;
        else if (tick_o)                   pre_q <= '0;
        else                               pre_q <= pre_q + ONE;
    end

    assert_pre_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i || restart_i) |=> (pre_q == '0));
    assert_pre_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (pre_q == '0));
endmodule

// File: rtl/tmr_counter.sv
// Module: down counter. Loads on request, steps on ticks and reports expiry
// when a tick finds it at zero. Assumes ticks never coincide with a load.
module tmr_counter #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic              reload_i,
    input  logic [DATA_W-1:0] modulus_i,
    output logic [DATA_W-1:0] cnt_o,
    output logic              expire_o
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] cnt_q;

    // Expiry detection
    always_comb expire_o = run_i && tick_i && !load_i && (cnt_q == '0);

    // Count register: load, refill or wrap on expiry, else decrement
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (load_i)            cnt_q <= load_val_i;
        else if (run_i && tick_i) begin
            if (cnt_q == '0)        cnt_q <= reload_i ? modulus_i : '1;
            else                    cnt_q <= cnt_q - ONE;
        end
    end

    assign cnt_o = cnt_q;

    assert_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(cnt_q));
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && reload_i) |=> (cnt_q == $past(modulus_i)));
    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !reload_i) |=> (cnt_q == '1));
endmodule

// File: rtl/tmr_top.sv
// Module: periodic interrupt timer top. Connects the register file,
// prescaler and down counter, and gates the level interrupt.
// Assumes the bus fabric presents one write per cycle at most.
module tmr_top
    import tmr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] modulus;
    logic [DATA_W-1:0] load_val;
    logic [DATA_W-1:0] cnt;
    logic              flag;
    logic              load;
    logic              tick;
    logic              expire;

    tmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .wdata_i(wdata_i), .expire_i(expire), .cnt_i(cnt), .ctrl_o(ctrl),
        .modulus_o(modulus), .flag_o(flag), .load_o(load),
        .load_val_o(load_val), .rdata_o(rdata_o)
    );

    tmr_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_i(ctrl.run), .restart_i(load),
        .sel_i(ctrl.sel), .tick_o(tick)
    );

    tmr_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_i(ctrl.run), .tick_i(tick),
        .load_i(load), .load_val_i(load_val), .reload_i(ctrl.reload),
        .modulus_i(modulus), .cnt_o(cnt), .expire_o(expire)
    );

    // Level interrupt gating
    always_comb irq_o = flag && ctrl.ie;

    assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (ctrl.ie && flag));
    assert_ovw_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(ADDR_MOD) && ctrl.ovw) |=> (cnt == $past(wdata_i)));
    assert_no_ovw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(ADDR_MOD) && !ctrl.ovw && !ctrl.run) |=> $stable(cnt));
endmodule

// File: tb/tmr_top_tb.sv
`timescale 1ns/1ps
module tmr_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [2:0] A_CTRL = 3'd0, A_MOD = 3'd2, A_CNT = 3'd4;

    tmr_top u_dut (.clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en),
                   .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

    always #2.5 clk = ~clk;

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = A_CTRL;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] cw(bit run, bit rl, bit ie, bit ovw, bit clr, int sel);
        logic [15:0] v;
        v = '0;
        v[0] = rl; v[1] = run; v[2] = clr; v[3] = ie; v[4] = ovw;
        v[11:8] = 4'(sel);
        return v;
    endfunction

    function automatic int divof(int sel);
        return 1 << (sel + 2);
    endfunction

    function automatic logic [15:0] exp_cnt(int md, int t, bit rl);
        if (rl) return 16'(md - (t % (md + 1)));
        if (t <= md) return 16'(md - t);
        return 16'(65535 - ((t - md - 1) % 65536));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, c0;
        void'($urandom(32'h5eed_1234));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        rd(A_CTRL, v); chk("R1 ctrl", v, 16'h0);
        rd(A_MOD, v);  chk("R1 mod", v, 16'h0);
        rd(A_CNT, v);  chk("R1 cnt", v, 16'h0);
        chk("R1 irq", 16'(irq), 16'h0);

        // R2 field layout, unused bits zero, modulus readback, count write ignored
        wr(A_CTRL, 16'hFFFF);
        rd(A_CTRL, v); chk("R2 ctrl layout", v, 16'h0F1B);
        wr(A_CTRL, cw(0, 0, 0, 0, 1, 0));
        wr(A_MOD, 16'h1234);
        rd(A_MOD, v); chk("R2 mod readback", v, 16'h1234);
        rd(A_CNT, c0);
        wr(A_CNT, 16'hABCD);
        rd(A_CNT, v); chk("R2 cnt write ignored", v, c0);
        rd(A_MOD, v); chk("R2 mod after cnt write", v, 16'h1234);

        // R3 divide select 5 gives a tick every 128 cycles
        wr(A_MOD, 16'd3);
        wr(A_CTRL, cw(1, 1, 0, 0, 0, 5));
        cyc(127);
        rd(A_CNT, v); chk("R3 before tick", v, 16'd3);
        cyc(1);
        rd(A_CNT, v); chk("R3 first tick", v, 16'd2);

        // R4 stop holds the count
        wr(A_CTRL, cw(0, 1, 0, 0, 1, 5));
        rd(A_CNT, c0);
        cyc(300);
        rd(A_CNT, v); chk("R4 hold while stopped", v, c0);
        // R4 max modulus load and first decrement
        wr(A_MOD, 16'hFFFF);
        wr(A_CTRL, cw(1, 1, 0, 0, 0, 0));
        rd(A_CNT, v); chk("R4 load on start", v, 16'hFFFF);
        cyc(4);
        rd(A_CNT, v); chk("R4 decrement", v, 16'hFFFE);

        // R6 one-shot wrap
        wr(A_CTRL, cw(0, 0, 0, 0, 1, 0));
        wr(A_MOD, 16'd2);
        wr(A_CTRL, cw(1, 0, 0, 0, 0, 0));
        cyc(11);
        rd(A_CTRL, v); chk("R6 no flag before expiry", 16'(v[2]), 16'h0);
        cyc(1);
        rd(A_CNT, v); chk("R6 wrap", v, 16'hFFFF);
        rd(A_CTRL, v); chk("R6 flag", 16'(v[2]), 16'h1);
        cyc(4);
        rd(A_CNT, v); chk("R6 keeps counting", v, 16'hFFFE);

        // R7 immediate load while running
        wr(A_CTRL, cw(0, 1, 0, 1, 1, 0));
        wr(A_MOD, 16'd50);
        wr(A_CTRL, cw(1, 1, 0, 1, 0, 0));
        cyc(21);
        wr(A_MOD, 16'd7);
        rd(A_CNT, v); chk("R7 immediate load", v, 16'd7);
        cyc(8);
        rd(A_CNT, v); chk("R7 prescaler restarted", v, 16'd5);
        // R7 without immediate load the count is untouched
        wr(A_CTRL, cw(0, 1, 0, 0, 1, 0));
        rd(A_CNT, c0);
        wr(A_MOD, 16'd30);
        rd(A_CNT, v); chk("R7 no overwrite", v, c0);
        rd(A_MOD, v); chk("R7 mod updated", v, 16'd30);

        // R8 / R9 flag clear and interrupt gating
        wr(A_MOD, 16'd1);
        wr(A_CTRL, cw(1, 1, 1, 0, 0, 0));
        cyc(20);
        chk("R9 irq high", 16'(irq), 16'h1);
        wr(A_CTRL, cw(0, 1, 1, 0, 0, 0));
        rd(A_CTRL, v); chk("R8 write 0 keeps flag", 16'(v[2]), 16'h1);
        chk("R9 irq still high", 16'(irq), 16'h1);
        wr(A_CTRL, cw(0, 1, 0, 0, 0, 0));
        chk("R9 irq masked", 16'(irq), 16'h0);
        wr(A_CTRL, cw(0, 1, 1, 0, 1, 0));
        rd(A_CTRL, v); chk("R8 write 1 clears", 16'(v[2]), 16'h0);
        chk("R9 irq low after clear", 16'(irq), 16'h0);

        // Random runs: R5 periodic and R6 one-shot against the tick model
        for (int i = 0; i < 24; i++) begin
            int md, sel, t, T;
            bit rl, ie;
            md  = 1 + int'($urandom % 40);
            sel = int'($urandom % 3);
            rl  = 1'($urandom % 2);
            ie  = 1'($urandom % 2);
            t   = int'($urandom % (divof(sel) * (md + 1) * 2 + 3));
            T   = t / divof(sel);
            wr(A_CTRL, cw(0, rl, ie, 0, 1, sel));
            wr(A_MOD, 16'(md));
            wr(A_CTRL, cw(1, rl, ie, 0, 0, sel));
            cyc(t);
            rd(A_CNT, v);
            if (rl) chk("R5 periodic count", v, exp_cnt(md, T, rl));
            else    chk("R6 one-shot count", v, exp_cnt(md, T, rl));
            rd(A_CTRL, v);
            chk("R5 flag", 16'(v[2]), 16'(T >= md + 1));
            chk("R9 irq", 16'(irq), 16'(ie && (T >= md + 1)));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule